// File: doc/BRIEF.md
# Supervisory Reset Timing Controller

This block produces the system reset for a digital subsystem from two requests. The first is a digital undervoltage flag that an external supply comparator drives. The second is an active-low manual-reset pin, typically wired to a push button. Reset is asserted while either request is present. Once both requests have cleared, reset stays asserted for a timeout chosen by a 2-bit select code.

Each request first passes through a two-flop synchronizer and then through its own qualification filter. The manual pin is debounced on both edges, so switch bounce and very short glitches have no effect. The undervoltage flag must persist for a configurable number of cycles before it counts, so short supply dips are rejected.

Three views of the same reset are driven: an active-high output, an active-low output, and an enable for an external open-drain pull-down. An asynchronous power-on reset forces reset asserted. After it is released, a full timeout must elapse before reset is released.

Top module: `sup_reset_ctrl`

## Requirements
- R1: The reset output is asserted whenever the qualified undervoltage request or the qualified manual request is present; the two combine as a logical OR, and overlapping requests keep reset asserted until the later one clears.
- R2: After the last request input returns inactive, reset is released exactly MR_HOLD+2+L (manual) or UV_HOLD+2+L (undervoltage) clock edges later, where L is the timeout length in cycles.
- R3: Timeout select code 2'd1 gives L = CLK_HZ×1.5 ms, 2'd2 gives CLK_HZ×30 ms, 2'd3 gives CLK_HZ×150 ms (integer cycles, rounded down), and 2'd0 behaves as 2'd1.
- R4: The manual-reset input is active low; a constant high level, which is the level of a floating pin held by a pull-up, never requests reset.
- R5: A manual-reset low pulse lasting fewer than MR_HOLD clock edges is ignored; a pulse of MR_HOLD edges or more asserts reset.
- R6: An undervoltage pulse lasting fewer than UV_HOLD clock edges is ignored and causes no reset.
- R7: Reset asserts exactly HOLD+3 clock edges after a request input becomes active, where HOLD is that input's filter length; at the default parameters this is well under 30 µs.
- R8: The active-low output is always the inverse of the active-high output, and the open-drain enable is high (drive low) exactly while reset is asserted.
- R9: If a request reasserts while the timeout is counting, the count is discarded and reset stays asserted; a full timeout starts again after the requests clear.
- R10: While the power-on reset is low, reset is asserted. After it is released with no request present, reset is released L+1 edges later, using the select code present at the first edge after release.
- R11: The select code is taken only while a request is present (or at the first edge after power-on reset); changing it during a running timeout does not change that timeout's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| uv_flag | input | 1 | Undervoltage flag from the supply comparator, active high, asynchronous |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| tmo_sel | input | 2 | Timeout select code (0/1 short, 2 medium, 3 long) |
| rst_out | output | 1 | System reset, active high |
| rst_out_n | output | 1 | System reset, active low |
| rst_od_en | output | 1 | Open-drain pull-down enable: 1 drives the reset line low, 0 releases it |

## Verification
Every result has a fixed due cycle when counted from the first clock edge that samples a new input level. Assertion lands HOLD+3 edges later: two synchronizer stages, HOLD filter edges and the timer register. Release lands HOLD+2+L edges after an input clears, and L+1 edges after power-on reset is released. The bench drives inputs on falling edges and counts rising edges until the output changes, checking on the falling edge that follows. It compares that count with the figure computed from the parameters. For glitch rejection and restarts, the bench watches the output over a window longer than any due cycle and requires it to stay put.

// File: rtl/sup_rst_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the supervisory reset controller.
// Assumes timeout lengths are given in microseconds and converted to
// clock cycles at elaboration time.
package sup_rst_pkg;

    localparam longint unsigned TMO_US_SHORT = 64'd1500;
    localparam longint unsigned TMO_US_MID   = 64'd30000;
    localparam longint unsigned TMO_US_LONG  = 64'd150000;

    typedef enum logic [1:0] {
        TMO_DEFAULT = 2'd0,
        TMO_SHORT   = 2'd1,
        TMO_MID     = 2'd2,
        TMO_LONG    = 2'd3
    } tmo_code_e;

    // Convert a duration in microseconds to a cycle count, at least one.
    function automatic longint unsigned us_to_cycles(input longint unsigned clk_hz,
                                                     input longint unsigned us);
        longint unsigned c;
        c = (clk_hz * us) / 64'd1000000;
        if (c == 64'd0) c = 64'd1;
        return c;
    endfunction

endpackage

// File: rtl/sup_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2; the chain resets to RST_VAL so that the
// downstream logic sees an idle level while power-on reset is low.
module sup_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sup_filter.sv
`timescale 1ns/1ps
// Symmetric qualification filter: the output follows the input only
// after the input has differed from it on HOLD consecutive edges.
// Shorter excursions are discarded. Assumes HOLD >= 1.
module sup_filter #(
    parameter int   HOLD    = 4,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);

    localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] run;

    // Count edges of disagreement and flip the output at the limit.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q   <= RST_VAL;
            run <= '0;
        end else if (d == q) begin
            run <= '0;
        end else if (run == LAST) begin
            q   <= d;
            run <= '0;
        end else begin
            run <= run + CW'(1);
        end
    end

endmodule

// File: rtl/sup_timer.sv
`timescale 1ns/1ps
// Reset hold timer. Holds reset while a request is present and for a
// selected number of quiet cycles afterwards. Assumes every limit is at
// least 1 and fits in CW bits. The select code is captured only while a
// request is present or on the first edge after power-on reset.
module sup_timer
    import sup_rst_pkg::*;
#(
    parameter int CW   = 12,
    parameter int LIM1 = 30,
    parameter int LIM2 = 600,
    parameter int LIM3 = 3000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       req,
    input  logic [1:0] sel,
    output logic       active
);

    tmo_code_e     sel_q;
    logic          fresh;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Translate the captured select code into a cycle limit.
    always_comb begin
        case (sel_q)
            TMO_MID:  limit = CW'(LIM2);
            TMO_LONG: limit = CW'(LIM3);
            default:  limit = CW'(LIM1);
        endcase
    end

    // Capture the select code, hold reset on requests, count the quiet time.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            active <= 1'b1;
            cnt    <= '0;
            sel_q  <= TMO_LONG;
            fresh  <= 1'b1;
        end else begin
            fresh <= 1'b0;
            if (req || fresh) sel_q <= tmo_code_e'(sel);
            if (req || fresh) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                if (cnt == limit - CW'(1)) begin
                    active <= 1'b0;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sup_reset_ctrl.sv
`timescale 1ns/1ps
// Supervisory reset timing controller (top).
// Synchronizes and filters the undervoltage flag and the active-low
// manual request, ORs them, and holds reset for a coded timeout after
// both clear. Assumes CLK_HZ is the real clock frequency; timeouts use
// nominal durations. Drives active-high, active-low and open-drain
// enable views of the same reset.
module sup_reset_ctrl
    import sup_rst_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 100_000_000,
    parameter int              MR_HOLD = 8,
    parameter int              UV_HOLD = 16,
    parameter int              STAGES  = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       uv_flag,
    input  logic       mr_n,
    input  logic [1:0] tmo_sel,
    output logic       rst_out,
    output logic       rst_out_n,
    output logic       rst_od_en
);

    localparam longint unsigned LIM_S = us_to_cycles(CLK_HZ, TMO_US_SHORT);
    localparam longint unsigned LIM_M = us_to_cycles(CLK_HZ, TMO_US_MID);
    localparam longint unsigned LIM_L = us_to_cycles(CLK_HZ, TMO_US_LONG);
    localparam int              TCW   = $clog2(LIM_L + 1);

    logic mr_s, uv_s;
    logic mr_q, uv_q;
    logic cond;
    logic hold;

    sup_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .por_n(por_n), .d(mr_n), .q(mr_s)
    );
    sup_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_uv_sync (
        .clk(clk), .por_n(por_n), .d(uv_flag), .q(uv_s)
    );

    sup_filter #(.HOLD(MR_HOLD), .RST_VAL(1'b1)) u_mr_filt (
        .clk(clk), .por_n(por_n), .d(mr_s), .q(mr_q)
    );
    sup_filter #(.HOLD(UV_HOLD), .RST_VAL(1'b0)) u_uv_filt (
        .clk(clk), .por_n(por_n), .d(uv_s), .q(uv_q)
    );

    // Either qualified request holds the system in reset.
    assign cond = uv_q | ~mr_q;

    sup_timer #(
        .CW(TCW), .LIM1(int'(LIM_S)), .LIM2(int'(LIM_M)), .LIM3(int'(LIM_L))
    ) u_timer (
        .clk(clk), .por_n(por_n), .req(cond), .sel(tmo_sel), .active(hold)
    );

    assign rst_out   = hold;
    assign rst_out_n = ~hold;
    assign rst_od_en = hold;

endmodule

// File: rtl/sup_reset_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for sup_reset_ctrl, bound to every instance.
// Keeps its own run-length counters of the synchronized inputs and of
// quiet reset time, and relates them to the filter and output behaviour.
module sup_reset_ctrl_chk #(
    parameter int              MR_HOLD = 8,
    parameter int              UV_HOLD = 16,
    parameter longint unsigned LIM_L   = 15_000_000
) (
    input logic clk,
    input logic por_n,
    input logic mr_s,
    input logic uv_s,
    input logic mr_q,
    input logic uv_q,
    input logic cond,
    input logic rst_out
);

    localparam int MW = $clog2(MR_HOLD + 1) + 1;
    localparam int UW = $clog2(UV_HOLD + 1) + 1;
    localparam int QW = $clog2(LIM_L + 3) + 1;

    logic [MW-1:0] mr_low_run;
    logic [UW-1:0] uv_high_run;
    logic [QW-1:0] quiet;

    // Saturating count of consecutive low edges on the synchronized manual pin.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                          mr_low_run <= '0;
        else if (mr_s)                       mr_low_run <= '0;
        else if (mr_low_run != MW'(MR_HOLD)) mr_low_run <= mr_low_run + MW'(1);
    end

    // Saturating count of consecutive high edges on the synchronized flag.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                           uv_high_run <= '0;
        else if (!uv_s)                       uv_high_run <= '0;
        else if (uv_high_run != UW'(UV_HOLD)) uv_high_run <= uv_high_run + UW'(1);
    end

    // Count edges spent in reset with no request present.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                           quiet <= '0;
        else if (rst_out && !cond && quiet != QW'(LIM_L + 2)) quiet <= quiet + QW'(1);
        else if (!(rst_out && !cond))         quiet <= '0;
    end

    AST_REQ_FORCES_RESET: assert property (@(posedge clk) disable iff (!por_n)
        cond |=> rst_out);                                         // R1

    AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out) |-> $past(!cond));                          // R2

    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        quiet <= QW'(LIM_L + 1));                                  // R3

    AST_MR_DEBOUNCED: assert property (@(posedge clk) disable iff (!por_n)
        $fell(mr_q) |-> mr_low_run >= MW'(MR_HOLD));               // R5

    AST_UV_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
        $rose(uv_q) |-> uv_high_run >= UW'(UV_HOLD));              // R6

    // Reset must be seen asserted on every edge inside power-on reset.
    always @(posedge clk) begin
        if (!por_n) begin
            AST_POR_HOLDS_RESET: assert (rst_out);                 // R10
        end
    end

endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(
    .MR_HOLD(MR_HOLD), .UV_HOLD(UV_HOLD), .LIM_L(LIM_L)
) u_chk (
    .clk(clk), .por_n(por_n), .mr_s(mr_s), .uv_s(uv_s),
    .mr_q(mr_q), .uv_q(uv_q), .cond(cond), .rst_out(rst_out)
);

// File: tb/sup_reset_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every select code and both request sources,
// plus glitch, overlap, restart, select-change and power-on cases.
module sup_reset_ctrl_test;

    localparam longint unsigned CLK_HZ  = 20_000;
    localparam int              MR_HOLD = 4;
    localparam int              UV_HOLD = 6;

    logic       clk = 1'b0;
    logic       por_n = 1'b1;
    logic       uv_flag = 1'b0;
    logic       mr_n = 1'b1;
    logic [1:0] tmo_sel = 2'd1;
    logic       rst_out, rst_out_n, rst_od_en;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sup_reset_ctrl #(.CLK_HZ(CLK_HZ), .MR_HOLD(MR_HOLD), .UV_HOLD(UV_HOLD)) uut (
        .clk(clk), .por_n(por_n), .uv_flag(uv_flag), .mr_n(mr_n),
        .tmo_sel(tmo_sel), .rst_out(rst_out), .rst_out_n(rst_out_n),
        .rst_od_en(rst_od_en)
    );

    function automatic int lim(input int code);
        longint unsigned us;
        us = (code == 2) ? 64'd30000 : (code == 3) ? 64'd150000 : 64'd1500;
        return int'((CLK_HZ * us) / 64'd1000000);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_views();
        chk("R8", "rst_out_n inverse", longint'(rst_out_n), longint'(!rst_out));
        chk("R8", "rst_od_en follows", longint'(rst_od_en), longint'(rst_out));
    endtask

    // Count rising edges until rst_out equals lvl; 0 if never within maxn.
    task automatic wait_level(input logic lvl, input int maxn, output int n);
        n = 0;
        for (int i = 1; i <= maxn; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_out == lvl) begin
                n = i;
                break;
            end
        end
    endtask

    // Count edges on which rst_out differs from lvl over a window.
    task automatic count_off(input logic lvl, input int cyc, output int bad);
        bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_out != lvl) bad++;
        end
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        int bad;
        int w;
        #1 por_n = 1'b0;
        idle(3);
        // R10: outputs asserted during power-on reset
        chk("R10", "rst_out in POR", longint'(rst_out), 1);
        chk_views();
        tmo_sel = 2'd1;
        por_n = 1'b1;
        wait_level(1'b0, lim(3) + 50, n);
        chk("R10", "POR release edges", n, lim(1) + 1);
        chk_views();

        // R4: high manual pin with no flag keeps reset released
        count_off(1'b0, 40, bad);
        chk("R4", "idle high pin bad edges", bad, 0);

        // R1/R2/R3/R7: every select code for each source
        for (int code = 0; code < 4; code++) begin
            for (int src = 0; src < 2; src++) begin
                int hold;
                hold = (src == 0) ? MR_HOLD : UV_HOLD;
                tmo_sel = 2'(code);
                if (src == 0) mr_n = 1'b0; else uv_flag = 1'b1;
                wait_level(1'b1, 100, n);
                chk("R7", "assert latency", n, hold + 3);
                chk("R1", "reset asserted", longint'(rst_out), 1);
                chk_views();
                chk("R7", "latency within 30us (ns)", (n * 10 <= 30000) ? 1 : 0, 1);
                idle(5);
                if (src == 0) mr_n = 1'b1; else uv_flag = 1'b0;
                wait_level(1'b0, lim(3) + 50, n);
                chk("R3", $sformatf("release code %0d src %0d", code, src), n, hold + 2 + lim(code));
                chk("R2", "released", longint'(rst_out), 0);
                chk_views();
                idle(3);
            end
        end

        // R1: overlapping requests hold reset until the later one clears
        tmo_sel = 2'd1;
        mr_n = 1'b0;
        wait_level(1'b1, 100, n);
        uv_flag = 1'b1;
        idle(20);
        mr_n = 1'b1;
        count_off(1'b1, 40, bad);
        chk("R1", "overlap hold bad edges", bad, 0);
        uv_flag = 1'b0;
        wait_level(1'b0, lim(3) + 50, n);
        chk("R2", "overlap release edges", n, UV_HOLD + 2 + lim(1));
        idle(3);

        // R5: manual glitch one edge short of the filter is ignored
        mr_n = 1'b0;
        idle(MR_HOLD - 1);
        mr_n = 1'b1;
        count_off(1'b0, 60, bad);
        chk("R5", "short manual pulse bad edges", bad, 0);

        // R6: undervoltage pulse one edge short is ignored
        uv_flag = 1'b1;
        idle(UV_HOLD - 1);
        uv_flag = 1'b0;
        count_off(1'b0, 60, bad);
        chk("R6", "short uv pulse bad edges", bad, 0);

        // R5: manual pulse of exactly the filter length is accepted
        mr_n = 1'b0;
        idle(MR_HOLD);
        mr_n = 1'b1;
        idle(4);
        chk("R5", "exact pulse asserted", longint'(rst_out), 1);
        wait_level(1'b0, lim(3) + 50, n);
        chk("R5", "exact pulse release edges", n, MR_HOLD + 2 + lim(1) - 4);
        idle(3);

        // R9: reassertion during the countdown restarts the timeout
        mr_n = 1'b0;
        wait_level(1'b1, 100, n);
        mr_n = 1'b1;
        idle(MR_HOLD + 2 + 10);
        chk("R9", "mid-count still asserted", longint'(rst_out), 1);
        mr_n = 1'b0;
        idle(MR_HOLD + 5);
        chk("R9", "reasserted still asserted", longint'(rst_out), 1);
        mr_n = 1'b1;
        wait_level(1'b0, lim(3) + 50, n);
        chk("R9", "restart release edges", n, MR_HOLD + 2 + lim(1));
        idle(3);

        // R11: a select change during countdown is not taken
        tmo_sel = 2'd3;
        uv_flag = 1'b1;
        wait_level(1'b1, 100, n);
        uv_flag = 1'b0;
        w = UV_HOLD + 7;
        idle(w);
        tmo_sel = 2'd1;
        wait_level(1'b0, lim(3) + 50, n);
        chk("R11", "select change ignored", n, UV_HOLD + 2 + lim(3) - w);
        idle(3);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule